// File: doc/BRIEF.md
# Edge-Latching Input Capture Channel

This block times an external signal. A down-counter is advanced by a count tick. The tick comes from a base clock enable, divided first by a programmable prescale factor and then by a power-of-two divider. The capture pin passes through a two-flop synchronizer. On each rising edge, the current counter value is stored in a rising-edge register, and on each falling edge it is stored in a separate falling-edge register. Each edge kind has its own sticky status flag and its own interrupt enable.

A request output can pass captured values to a DMA engine. It can offer only rising values, only falling values, or rising/falling pairs. For pairs, a control bit chooses which value of the pair is offered first. A request stays asserted until the engine acknowledges it. Software reaches the block through plain level and pulse inputs: enables, the reload value, divider settings, write-one-to-clear strobes and run start/stop pulses.

Top module: `cap_channel`

## Requirements
- R1: After reset, `count`, both latches, `flags`, `irq`, `dma_req` and `running` are all zero.
- R2: While running with `base_tick` high, `count` steps once every P*D cycles. P = max(`presc`,1)+1, so the prescale factor is at least 2. D = 2^`div_sel` for `div_sel` 0..4, and 16 for larger codes.
- R3: A `run_set` pulse sets `running` and loads `count` with `period`. A tick at count 0 reloads `period`, so the sequence for period 3 is 3,2,1,0,3.
- R4: A pin edge is latched three clock edges after the pin changes. Each latch receives the `count` value held between the second and third of those edges. Rising edges go to `rise_latch` and falling edges go to `fall_latch`.
- R5: An edge is captured, and sets a flag, only while both `cap_en` and `pad_en` are high. Otherwise both latches and both flags stay unchanged.
- R6: `flags[0]` (rising) and `flags[1]` (falling) are sticky. Each is cleared by a one on the matching `flag_clr` bit, and a clear bit of zero leaves its flag alone.
- R7: `irq` equals (`flags[0]` and `ie_rise`) or (`flags[1]` and `ie_fall`).
- R8: Deasserting `cap_en` clears `running` on the following clock edge, which freezes `count`.
- R9: `dma_mode` codes are: 2'b01 offers rising captures only, 2'b10 offers falling captures only, 2'b11 offers pairs, and 2'b00 offers nothing. In a single mode, an edge of the other kind raises no request.
- R10: In pair mode, `dma_fall_first`=0 offers the rising value before the falling value, and `dma_fall_first`=1 offers the falling value first. An edge of the second kind arriving before any first-kind capture is not offered.
- R11: `dma_req` holds until `dma_ack`. A same-kind edge arriving while a request is pending updates `dma_data` but produces one request, not two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Source clock enable feeding the prescaler |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_en | input | 1 | Capture enable |
| pad_en | input | 1 | Pin path enable |
| run_set | input | 1 | Start pulse: load period and run |
| run_clr | input | 1 | Stop pulse |
| period | input | CNT_W | Reload value |
| presc | input | PRE_W | Prescale setting (factor = max(presc,1)+1) |
| div_sel | input | 3 | Divider code |
| ie_rise | input | 1 | Rising-flag interrupt enable |
| ie_fall | input | 1 | Falling-flag interrupt enable |
| flag_clr | input | 2 | Write-one-to-clear strobe per flag |
| dma_en | input | 1 | DMA request enable; low clears pending requests |
| dma_mode | input | 2 | DMA selection code |
| dma_fall_first | input | 1 | Pair order select |
| dma_ack | input | 1 | DMA acknowledge |
| count | output | CNT_W | Counter value |
| running | output | 1 | Counter running |
| rise_latch | output | CNT_W | Count at the last rising capture |
| fall_latch | output | CNT_W | Count at the last falling capture |
| flags | output | 2 | Sticky capture flags {fall, rise} |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request |
| dma_data | output | CNT_W | Value offered to DMA |

## Verification
The request-hold property assumes that `dma_mode` and `dma_fall_first` change only while `dma_en` is low. The stimulus therefore drops `dma_en`, changes the mode, and then raises `dma_en` again. The counter-bound property assumes that `period` changes only while the counter is stopped, and the bench reprograms it only after a `run_clr` pulse. The capture pin is driven on falling clock edges and held for at least three cycles, so each level crosses the synchronizer cleanly.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        DMA_OFF  = 2'b00,
        DMA_RISE = 2'b01,
        DMA_FALL = 2'b10,
        DMA_PAIR = 2'b11
    } dma_mode_e;

    localparam int unsigned DIV_SEL_W = 3;
    localparam int unsigned DIV_MAX_LOG = 4;
    localparam int unsigned DIV_CNT_W = DIV_MAX_LOG + 1;
endpackage

// File: rtl/cap_tick_gen.sv
module cap_tick_gen
    import cap_pkg::*;
#(
    parameter int unsigned PRE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 base_tick,
    input  logic [PRE_W-1:0]     presc,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    typedef struct packed {
        logic [PRE_W-1:0]     pcnt;
        logic [DIV_CNT_W-1:0] dcnt;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic [PRE_W-1:0]     fac_m1;
    logic [DIV_CNT_W-1:0] div_m1;
    logic                 stage;

    always_comb begin
        fac_m1 = (presc == '0) ? PRE_W'(1) : presc;
        if (div_sel >= DIV_SEL_W'(DIV_MAX_LOG))
            div_m1 = DIV_CNT_W'((1 << DIV_MAX_LOG) - 1);
        else
            div_m1 = DIV_CNT_W'((DIV_CNT_W'(1) << div_sel) - DIV_CNT_W'(1));
        stage = base_tick && (st_q.pcnt == fac_m1);
        tick  = en && stage && (st_q.dcnt == div_m1);
        st_d  = st_q;
        if (!en) begin
            st_d = '0;
        end else if (base_tick) begin
            st_d.pcnt = stage ? '0 : st_q.pcnt + 1'b1;
            if (stage)
                st_d.dcnt = tick ? '0 : st_q.dcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[CHAIN-2:0], pin};
        rise = sh_q[STAGES-1] && !sh_q[STAGES];
        fall = !sh_q[STAGES-1] && sh_q[STAGES];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/cap_dma_seq.sv
module cap_dma_seq
    import cap_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  dma_mode_e        mode,
    input  logic             fall_first,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic [CNT_W-1:0] rise_val,
    input  logic [CNT_W-1:0] fall_val,
    input  logic             ack,
    output logic             req,
    output logic [CNT_W-1:0] data
);
    typedef struct packed {
        logic pend_r;
        logic pend_f;
        logic phase;
    } dq_state_t;

    dq_state_t st_d, st_q;
    logic pair, pend_first, pend_second, sel_fall, take;
    logic set_r, set_f, first_evt, second_evt;

    always_comb begin
        pair        = (mode == DMA_PAIR);
        pend_first  = fall_first ? st_q.pend_f : st_q.pend_r;
        pend_second = fall_first ? st_q.pend_r : st_q.pend_f;
        first_evt   = fall_first ? fall_evt : rise_evt;
        second_evt  = fall_first ? rise_evt : fall_evt;

        if (pair) begin
            req      = st_q.phase ? pend_second : pend_first;
            sel_fall = st_q.phase ? !fall_first : fall_first;
        end else begin
            req      = (mode == DMA_RISE) ? st_q.pend_r :
                       (mode == DMA_FALL) ? st_q.pend_f : 1'b0;
            sel_fall = (mode == DMA_FALL);
        end
        data = sel_fall ? fall_val : rise_val;
        take = req && ack;

        set_r = 1'b0;
        set_f = 1'b0;
        if (pair) begin
            if (first_evt && !st_q.phase) begin
                if (fall_first) set_f = 1'b1;
                else            set_r = 1'b1;
            end
            if (second_evt && (st_q.phase || pend_first)) begin
                if (fall_first) set_r = 1'b1;
                else            set_f = 1'b1;
            end
        end else begin
            set_r = rise_evt && (mode == DMA_RISE);
            set_f = fall_evt && (mode == DMA_FALL);
        end

        st_d = st_q;
        if (take) begin
            if (sel_fall) st_d.pend_f = 1'b0;
            else          st_d.pend_r = 1'b0;
            if (pair)     st_d.phase  = !st_q.phase;
        end
        if (set_r) st_d.pend_r = 1'b1;
        if (set_f) st_d.pend_f = 1'b1;
        if (!en)   st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned PRE_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_tick,
    input  logic                 cap_pin,
    input  logic                 cap_en,
    input  logic                 pad_en,
    input  logic                 run_set,
    input  logic                 run_clr,
    input  logic [CNT_W-1:0]     period,
    input  logic [PRE_W-1:0]     presc,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 ie_rise,
    input  logic                 ie_fall,
    input  logic [1:0]           flag_clr,
    input  logic                 dma_en,
    input  logic [1:0]           dma_mode,
    input  logic                 dma_fall_first,
    input  logic                 dma_ack,
    output logic [CNT_W-1:0]     count,
    output logic                 running,
    output logic [CNT_W-1:0]     rise_latch,
    output logic [CNT_W-1:0]     fall_latch,
    output logic [1:0]           flags,
    output logic                 irq,
    output logic                 dma_req,
    output logic [CNT_W-1:0]     dma_data
);
    typedef struct packed {
        logic             run;
        logic             cap_en_prev;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] r_lat;
        logic [CNT_W-1:0] f_lat;
        logic [1:0]       flg;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic tick, rise_det, fall_det, rise_evt, fall_evt, cap_on;

    cap_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(st_q.run), .base_tick(base_tick),
        .presc(presc), .div_sel(div_sel), .tick(tick)
    );

    cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(rise_det), .fall(fall_det)
    );

    cap_dma_seq #(.CNT_W(CNT_W)) u_dma (
        .clk(clk), .rst_n(rst_n), .en(dma_en), .mode(dma_mode_e'(dma_mode)),
        .fall_first(dma_fall_first), .rise_evt(rise_evt), .fall_evt(fall_evt),
        .rise_val(st_q.r_lat), .fall_val(st_q.f_lat), .ack(dma_ack),
        .req(dma_req), .data(dma_data)
    );

    always_comb begin
        cap_on   = cap_en && pad_en;
        rise_evt = cap_on && rise_det;
        fall_evt = cap_on && fall_det;

        st_d = st_q;
        st_d.cap_en_prev = cap_en;

        if (run_set) begin
            st_d.run = 1'b1;
            st_d.cnt = period;
        end else if (st_q.run && tick) begin
            st_d.cnt = (st_q.cnt == '0) ? period : st_q.cnt - 1'b1;
        end
        if (run_clr || (st_q.cap_en_prev && !cap_en))
            st_d.run = 1'b0;

        if (rise_evt) st_d.r_lat = st_q.cnt;
        if (fall_evt) st_d.f_lat = st_q.cnt;

        st_d.flg = (st_q.flg & ~flag_clr) | {fall_evt, rise_evt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count      = st_q.cnt;
    assign running    = st_q.run;
    assign rise_latch = st_q.r_lat;
    assign fall_latch = st_q.f_lat;
    assign flags      = st_q.flg;
    assign irq        = (st_q.flg[0] && ie_rise) || (st_q.flg[1] && ie_fall);
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_en,
    input logic             pad_en,
    input logic             ie_rise,
    input logic             ie_fall,
    input logic             irq,
    input logic [1:0]       flags,
    input logic [CNT_W-1:0] rise_latch,
    input logic [CNT_W-1:0] fall_latch,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             running,
    input logic             dma_en,
    input logic             dma_req,
    input logic             dma_ack
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_rise && !ie_fall) |-> !irq); // R7

    AST_LATCH_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en && pad_en) |=> ($stable(rise_latch) && $stable(fall_latch))); // R5

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(cap_en && pad_en)); // R5

    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_en) |=> !running); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && dma_en) |=> (dma_req || !dma_en)); // R11

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $stable(period) && (count <= period)) |=> (count <= period)); // R3
endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_cap_channel.sv
module tb_cap_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b1;
    logic        cap_pin = 1'b0;
    logic        cap_en = 1'b0, pad_en = 1'b0;
    logic        run_set = 1'b0, run_clr = 1'b0;
    logic [15:0] period = 16'd100;
    logic [7:0]  presc = 8'd0;
    logic [2:0]  div_sel = 3'd0;
    logic        ie_rise = 1'b0, ie_fall = 1'b0;
    logic [1:0]  flag_clr = 2'b00;
    logic        dma_en = 1'b0;
    logic [1:0]  dma_mode = 2'b00;
    logic        dma_fall_first = 1'b0;
    logic        dma_ack = 1'b0;
    logic [15:0] count, rise_latch, fall_latch, dma_data;
    logic        running, irq, dma_req;
    logic [1:0]  flags;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cap_channel dut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .cap_pin(cap_pin),
        .cap_en(cap_en), .pad_en(pad_en), .run_set(run_set), .run_clr(run_clr),
        .period(period), .presc(presc), .div_sel(div_sel), .ie_rise(ie_rise),
        .ie_fall(ie_fall), .flag_clr(flag_clr), .dma_en(dma_en),
        .dma_mode(dma_mode), .dma_fall_first(dma_fall_first), .dma_ack(dma_ack),
        .count(count), .running(running), .rise_latch(rise_latch),
        .fall_latch(fall_latch), .flags(flags), .irq(irq), .dma_req(dma_req),
        .dma_data(dma_data)
    );

    // presc, div_sel, expected cycles per count step (R2)
    localparam int RATE_TBL [8][3] = '{
        '{0, 0, 2}, '{1, 0, 2}, '{2, 0, 3}, '{3, 1, 8},
        '{1, 2, 8}, '{0, 4, 32}, '{4, 3, 40}, '{2, 7, 48}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_run(input bit start);
        @(negedge clk);
        if (start) run_set = 1'b1; else run_clr = 1'b1;
        @(negedge clk);
        run_set = 1'b0;
        run_clr = 1'b0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = 2'b00;
    endtask

    task automatic do_ack();
        @(negedge clk) dma_ack = 1'b1;
        @(negedge clk) dma_ack = 1'b0;
    endtask

    task automatic set_dma(input logic [1:0] m, input logic ff);
        @(negedge clk) dma_en = 1'b0;
        @(negedge clk) begin dma_mode = m; dma_fall_first = ff; end
        @(negedge clk) dma_en = 1'b1;
    endtask

    // drive pin, return the count held between the 2nd and 3rd edge (R4)
    task automatic pin_edge(input logic v, output logic [15:0] exp);
        @(negedge clk) cap_pin = v;
        @(posedge clk);
        @(posedge clk);
        #1 exp = count;
        @(posedge clk);
        #1;
    endtask

    task automatic wait_change(output int n);
        logic [15:0] c0;
        c0 = count;
        n = 0;
        while (count == c0 && n < 300) begin
            @(posedge clk);
            #1 n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] e1, e2;
        int n;
        repeat (3) @(posedge clk);
        #1;
        chk(count == 0 && rise_latch == 0 && fall_latch == 0, "R1 count/latches", count, 0);
        chk(flags == 0 && !irq && !dma_req && !running, "R1 flags/irq/req/run",
            {flags, irq, dma_req, running}, 0);
        @(negedge clk) rst_n = 1'b1;
        cap_en = 1'b1;
        pad_en = 1'b1;

        // R2 rate table
        for (int i = 0; i < 8; i++) begin
            pulse_run(1'b0);
            @(negedge clk) begin
                presc = 8'(RATE_TBL[i][0]);
                div_sel = 3'(RATE_TBL[i][1]);
                period = 16'd100;
            end
            pulse_run(1'b1);
            #1;
            wait_change(n);
            wait_change(n);
            chk(n == RATE_TBL[i][2], "R2 step interval", n, RATE_TBL[i][2]);
        end

        // R3 start load and reload
        pulse_run(1'b0);
        @(negedge clk) begin presc = 8'd0; div_sel = 3'd0; period = 16'd3; end
        pulse_run(1'b1);
        #1 chk(running && count == 3, "R3 start load", count, 3);
        wait_change(n); chk(count == 2, "R3 step", count, 2);
        wait_change(n); chk(count == 1, "R3 step", count, 1);
        wait_change(n); chk(count == 0, "R3 step", count, 0);
        wait_change(n); chk(count == 3, "R3 reload", count, 3);

        pulse_run(1'b0);
        @(negedge clk) period = 16'd200;
        pulse_run(1'b1);
        repeat (5) @(negedge clk);

        // R4 capture values, R6 flags
        pin_edge(1'b1, e1);
        chk(rise_latch == e1, "R4 rise latch", rise_latch, e1);
        chk(flags == 2'b01, "R6 rise flag", flags, 1);
        repeat (7) @(negedge clk);
        pin_edge(1'b0, e2);
        chk(fall_latch == e2, "R4 fall latch", fall_latch, e2);
        chk(rise_latch == e1, "R4 rise latch kept", rise_latch, e1);
        chk(flags == 2'b11, "R6 both flags", flags, 3);

        // R7 irq gating
        @(negedge clk) ie_rise = 1'b1;
        #1 chk(irq, "R7 irq rise enabled", irq, 1);
        pulse_clr(2'b01);
        #1 chk(flags == 2'b10, "R6 clear rise only", flags, 2);
        chk(!irq, "R7 irq with fall flag masked", irq, 0);
        @(negedge clk) ie_fall = 1'b1;
        #1 chk(irq, "R7 irq fall enabled", irq, 1);
        pulse_clr(2'b10);
        #1 chk(flags == 2'b00 && !irq, "R6 clear fall", {flags, irq}, 0);
        pulse_clr(2'b00);
        @(negedge clk) begin ie_rise = 1'b0; ie_fall = 1'b0; end

        // R5 capture gating
        @(negedge clk) pad_en = 1'b0;
        pin_edge(1'b1, e2);
        pin_edge(1'b0, e2);
        chk(rise_latch == e1 && flags == 0, "R5 pad disabled", rise_latch, e1);
        @(negedge clk) begin pad_en = 1'b1; cap_en = 1'b0; end
        pin_edge(1'b1, e2);
        chk(rise_latch == e1 && flags == 0, "R5 capture disabled", rise_latch, e1);

        // R8 disable stops counter
        chk(!running, "R8 running cleared", running, 0);
        e2 = count;
        repeat (6) @(negedge clk);
        chk(count == e2, "R8 count frozen", count, e2);
        pin_edge(1'b0, e2);
        @(negedge clk) cap_en = 1'b1;
        pulse_run(1'b1);
        pulse_clr(2'b11);

        // R9 single modes
        set_dma(2'b01, 1'b0);
        pin_edge(1'b1, e1);
        chk(dma_req && dma_data == e1, "R9 rise request", dma_data, e1);
        do_ack();
        #1 chk(!dma_req, "R9 ack drops", dma_req, 0);
        pin_edge(1'b0, e2);
        chk(!dma_req, "R9 fall ignored in rise mode", dma_req, 0);
        set_dma(2'b10, 1'b0);
        pin_edge(1'b1, e1);
        chk(!dma_req, "R9 rise ignored in fall mode", dma_req, 0);
        pin_edge(1'b0, e2);
        chk(dma_req && dma_data == e2, "R9 fall request", dma_data, e2);
        do_ack();
        set_dma(2'b00, 1'b0);
        pin_edge(1'b1, e1);
        chk(!dma_req, "R9 mode off", dma_req, 0);
        pin_edge(1'b0, e2);

        // R11 overwrite without duplicate
        set_dma(2'b01, 1'b0);
        pin_edge(1'b1, e1);
        pin_edge(1'b0, e2);
        repeat (3) @(negedge clk);
        pin_edge(1'b1, e1);
        chk(dma_req && dma_data == e1, "R11 overwrite latest", dma_data, e1);
        do_ack();
        #1 chk(!dma_req, "R11 single request", dma_req, 0);
        pin_edge(1'b0, e2);

        // R10 pair ordering
        set_dma(2'b11, 1'b0);
        pin_edge(1'b1, e1);
        chk(dma_req && dma_data == e1, "R10 rising first", dma_data, e1);
        pin_edge(1'b0, e2);
        chk(dma_req && dma_data == e1, "R11 held before ack", dma_data, e1);
        do_ack();
        #1 chk(dma_req && dma_data == e2, "R10 falling second", dma_data, e2);
        do_ack();
        #1 chk(!dma_req, "R10 pair done", dma_req, 0);
        set_dma(2'b11, 1'b1);
        pin_edge(1'b1, e1);
        chk(!dma_req, "R10 second kind alone ignored", dma_req, 0);
        pin_edge(1'b0, e2);
        chk(dma_req && dma_data == e2, "R10 falling first", dma_data, e2);
        pin_edge(1'b1, e1);
        do_ack();
        #1 chk(dma_req && dma_data == e1, "R10 rising second", dma_data, e1);
        do_ack();
        #1 chk(!dma_req, "R10 order1 done", dma_req, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule